// File: doc/BRIEF.md
# Physical Memory Protection Checker

This block decides whether a memory access may proceed. It holds a table of sixteen protection entries. Each entry has an 8-bit configuration and a 32-bit bound register, and software loads them through a simple write port. It also provides a read port so that software can read the stored values back. On every cycle the block looks at the access address, the access kind and the privilege level. From these it returns a combinational allow or deny result. It also reports which entry decided the result.

An entry can be switched off, can cover the span between the previous entry's bound and its own bound, or can cover a naturally aligned power-of-two region. The size of such a region is set by the trailing ones in its bound register. Setting the lock bit does two things: it freezes the entry's registers, and it forces machine-mode accesses through the entry's permission bits.

Top module: `pmp_guard`

## Requirements
- R1: A configuration byte is stored with bit 0 = read, bit 1 = write, bit 2 = execute, bits 4:3 = match mode, bit 7 = lock. Bits 6:5 always read back as zero. A read of a configuration (`rd_sel`=0) returns the byte in bits 7:0 with zeros above. A read of a bound (`rd_sel`=1) returns the full 32-bit word.
- R2: After a synchronous reset, every configuration and every bound register reads zero.
- R3: While an entry's lock bit is 1, writes to its configuration or its bound leave both unchanged. Only reset clears the lock.
- R4: An entry whose match mode is 0 or 2 never matches.
- R5: Mode 1 (top of range) compares the access word address `acc_addr[33:2]`. Entry 0 matches when the word address is below its own bound. Entry i matches when bound[i-1] <= word address < bound[i].
- R6: In mode 3 (aligned region), a bound with k trailing ones covers 2^(k+3) bytes. The region's base is the bound with those k+1 low bits cleared, shifted left by two. A bound of all ones matches every address.
- R7: When several entries match, the entry with the lowest index decides the result.
- R8: The access kind selects the permission bit that applies: 0 = read (bit 0), 1 = write (bit 1), 2 or 3 = fetch (bit 2).
- R9: A machine-mode access (`acc_mmode`=1) that matches an unlocked entry is allowed. A matching locked entry applies its permission bits to machine mode too.
- R10: When no entry matches, a machine-mode access is allowed and a lower-privilege access is denied.
- R11: `acc_hit` is 1 exactly when some entry matches. When it is 1, `acc_idx` gives the lowest matching index.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| wr_en | input | 1 | Register write strobe |
| wr_sel | input | 1 | 0 = configuration, 1 = bound |
| wr_idx | input | 4 | Entry written |
| wr_data | input | 32 | Write data (configuration uses bits 7:0) |
| rd_sel | input | 1 | 0 = configuration, 1 = bound |
| rd_idx | input | 4 | Entry read |
| rd_data | output | 32 | Read data |
| acc_addr | input | 34 | Byte address of the access |
| acc_kind | input | 2 | Access kind |
| acc_mmode | input | 1 | 1 = machine privilege |
| acc_allow | output | 1 | Access permitted |
| acc_hit | output | 1 | Some entry matched |
| acc_idx | output | 4 | Lowest matching entry |

## Verification
The hardest situation to reach is a locked entry that overlaps a higher, unlocked entry, combined with a machine-mode access. Only in that case do R7 and R9 both affect the result. The stimulus programs the overlapping regions first and then sets the lock as the last write. It then probes addresses on both sides of each region edge, for every access kind and both privilege levels. Randomised sequences then mix top-of-range chains, aligned regions of every size and occasional locks inside a small address window, so that region edges are hit often.

// File: rtl/pmp_pkg.sv
package pmp_pkg;

    localparam int unsigned ENTRY_COUNT = 16;
    localparam int unsigned BOUND_W     = 32;

    typedef enum logic [1:0] {
        MATCH_OFF   = 2'd0,
        MATCH_RANGE = 2'd1,
        MATCH_WORD4 = 2'd2,
        MATCH_POW2  = 2'd3
    } match_mode_e;

    typedef enum logic [1:0] {
        KIND_LOAD  = 2'd0,
        KIND_STORE = 2'd1,
        KIND_FETCH = 2'd2,
        KIND_FETCH_ALT = 2'd3
    } access_kind_e;

    typedef enum logic {
        SEL_CFG   = 1'b0,
        SEL_BOUND = 1'b1
    } reg_sel_e;

    // Field order follows the configuration byte: lock is bit 7, read is bit 0.
    typedef struct packed {
        logic        lock;
        logic [1:0]  rsvd;
        match_mode_e mode;
        logic        x;
        logic        w;
        logic        r;
    } entry_cfg_t;

    function automatic entry_cfg_t clean_cfg(logic [7:0] raw);
        entry_cfg_t c;
        c      = entry_cfg_t'(raw);
        c.rsvd = 2'b00;
        return c;
    endfunction

    function automatic logic kind_permitted(entry_cfg_t c, access_kind_e k);
        logic ok;
        case (k)
            KIND_LOAD:  ok = c.r;
            KIND_STORE: ok = c.w;
            default:    ok = c.x;
        endcase
        return ok;
    endfunction

endpackage

// File: rtl/pmp_regs.sv
module pmp_regs
    import pmp_pkg::*;
#(
    parameter int unsigned N  = 16,
    parameter int unsigned AW = 32,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic            clk,
    input  logic            rst,
    input  logic            wr_en,
    input  reg_sel_e        wr_sel,
    input  logic [IW-1:0]   wr_idx,
    input  logic [AW-1:0]   wr_data,
    output entry_cfg_t      cfg_q  [N],
    output logic [AW-1:0]   bound_q [N]
);

    always_ff @(posedge clk) begin
        for (int i = 0; i < N; i++) begin
            if (rst) begin
                cfg_q[i]   <= '0;
                bound_q[i] <= '0;
            end else if (wr_en && wr_idx == IW'(i) && !cfg_q[i].lock) begin
                if (wr_sel == SEL_CFG) begin
                    cfg_q[i] <= clean_cfg(wr_data[7:0]);
                end else begin
                    bound_q[i] <= wr_data;
                end
            end
        end
    end

endmodule

// File: rtl/pmp_match.sv
module pmp_match
    import pmp_pkg::*;
#(
    parameter int unsigned AW = 32
) (
    input  entry_cfg_t    cfg,
    input  logic [AW-1:0] bound,
    input  logic [AW-1:0] lower,
    input  logic [AW-1:0] word_addr,
    output logic          hit
);

    logic [AW-1:0] span_mask;
    logic          in_range;
    logic          in_pow2;

    // Trailing ones plus the next zero bit give the ignored low bits.
    assign span_mask = bound ^ (bound + AW'(1));
    assign in_range  = (word_addr >= lower) && (word_addr < bound);
    assign in_pow2   = ((word_addr ^ bound) & ~span_mask) == '0;

    always_comb begin
        case (cfg.mode)
            MATCH_RANGE: hit = in_range;
            MATCH_POW2:  hit = in_pow2;
            default:     hit = 1'b0;
        endcase
    end

endmodule

// File: rtl/pmp_pick.sv
module pmp_pick #(
    parameter int unsigned N = 16,
    localparam int unsigned IW = $clog2(N)
) (
    input  logic [N-1:0]  hits,
    output logic          found,
    output logic [IW-1:0] idx
);

    always_comb begin
        found = 1'b0;
        idx   = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (hits[i]) begin
                found = 1'b1;
                idx   = IW'(i);
            end
        end
    end

endmodule

// File: rtl/pmp_guard.sv
module pmp_guard
    import pmp_pkg::*;
#(
    parameter int unsigned NUM_ENTRIES = ENTRY_COUNT,
    parameter int unsigned ADDR_W      = BOUND_W,
    localparam int unsigned IDX_W      = $clog2(NUM_ENTRIES),
    localparam int unsigned PA_W       = ADDR_W + 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              wr_sel,
    input  logic [IDX_W-1:0]  wr_idx,
    input  logic [ADDR_W-1:0] wr_data,
    input  logic              rd_sel,
    input  logic [IDX_W-1:0]  rd_idx,
    output logic [ADDR_W-1:0] rd_data,
    input  logic [PA_W-1:0]   acc_addr,
    input  logic [1:0]        acc_kind,
    input  logic              acc_mmode,
    output logic              acc_allow,
    output logic              acc_hit,
    output logic [IDX_W-1:0]  acc_idx
);

    entry_cfg_t              cfg_q   [NUM_ENTRIES];
    logic [ADDR_W-1:0]       bound_q [NUM_ENTRIES];
    logic [NUM_ENTRIES-1:0]  hits;
    logic [ADDR_W-1:0]       word_addr;
    entry_cfg_t              win_cfg;
    logic                    unused_lsb;

    assign word_addr  = acc_addr[PA_W-1:2];
    assign unused_lsb = &acc_addr[1:0];

    pmp_regs #(.N(NUM_ENTRIES), .AW(ADDR_W)) u_regs (
        .clk     (clk),
        .rst     (rst),
        .wr_en   (wr_en),
        .wr_sel  (reg_sel_e'(wr_sel)),
        .wr_idx  (wr_idx),
        .wr_data (wr_data),
        .cfg_q   (cfg_q),
        .bound_q (bound_q)
    );

    generate
        for (genvar g = 0; g < NUM_ENTRIES; g++) begin : g_entry
            logic [ADDR_W-1:0] lower;
            if (g == 0) begin : g_first
                assign lower = '0;
            end else begin : g_rest
                assign lower = bound_q[g-1];
            end
            pmp_match #(.AW(ADDR_W)) u_match (
                .cfg       (cfg_q[g]),
                .bound     (bound_q[g]),
                .lower     (lower),
                .word_addr (word_addr),
                .hit       (hits[g])
            );
        end
    endgenerate

    pmp_pick #(.N(NUM_ENTRIES)) u_pick (
        .hits  (hits),
        .found (acc_hit),
        .idx   (acc_idx)
    );

    assign win_cfg = cfg_q[acc_idx];

    always_comb begin
        if (acc_hit) begin
            acc_allow = (acc_mmode && !win_cfg.lock)
                      || kind_permitted(win_cfg, access_kind_e'(acc_kind));
        end else begin
            acc_allow = acc_mmode;
        end
    end

    always_comb begin
        if (reg_sel_e'(rd_sel) == SEL_BOUND) begin
            rd_data = bound_q[rd_idx];
        end else begin
            rd_data = {{(ADDR_W-8){1'b0}}, cfg_q[rd_idx]};
        end
    end

endmodule

// File: rtl/pmp_guard_sva.sv
module pmp_guard_sva
    import pmp_pkg::*;
#(
    parameter int unsigned N  = 16,
    parameter int unsigned AW = 32,
    localparam int unsigned IW = $clog2(N)
) (
    input logic          clk,
    input logic          rst,
    input logic [1:0]    acc_kind,
    input logic          acc_mmode,
    input logic          acc_allow,
    input logic          acc_hit,
    input logic [IW-1:0] acc_idx,
    input entry_cfg_t    cfg_q   [N],
    input logic [AW-1:0] bound_q [N]
);

    generate
        for (genvar g = 0; g < N; g++) begin : g_lock
            assert_lock_cfg_frozen_R3: assert property (@(posedge clk) disable iff (rst)
                cfg_q[g].lock |=> $stable(cfg_q[g]));
            assert_lock_bound_frozen_R3: assert property (@(posedge clk) disable iff (rst)
                cfg_q[g].lock |=> $stable(bound_q[g]));
            assert_rsvd_zero_R1: assert property (@(posedge clk) disable iff (rst)
                cfg_q[g].rsvd == 2'b00);
        end
    endgenerate

    assert_winner_mode_live_R4: assert property (@(posedge clk) disable iff (rst)
        acc_hit |-> (cfg_q[acc_idx].mode == MATCH_RANGE || cfg_q[acc_idx].mode == MATCH_POW2));

    assert_miss_by_privilege_R10: assert property (@(posedge clk) disable iff (rst)
        !acc_hit |-> (acc_allow == acc_mmode));

    assert_machine_unlocked_R9: assert property (@(posedge clk) disable iff (rst)
        (acc_hit && acc_mmode && !cfg_q[acc_idx].lock) |-> acc_allow);

    assert_perm_bit_R8: assert property (@(posedge clk) disable iff (rst)
        (acc_hit && (!acc_mmode || cfg_q[acc_idx].lock)) |->
        (acc_allow == (acc_kind[1] ? cfg_q[acc_idx].x :
                       acc_kind[0] ? cfg_q[acc_idx].w : cfg_q[acc_idx].r)));

endmodule

bind pmp_guard pmp_guard_sva #(.N(NUM_ENTRIES), .AW(ADDR_W)) u_sva (
    .clk       (clk),
    .rst       (rst),
    .acc_kind  (acc_kind),
    .acc_mmode (acc_mmode),
    .acc_allow (acc_allow),
    .acc_hit   (acc_hit),
    .acc_idx   (acc_idx),
    .cfg_q     (cfg_q),
    .bound_q   (bound_q)
);

// File: tb/test_pmp_guard.sv
module test_pmp_guard;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        wr_en = 1'b0;
    logic        wr_sel = 1'b0;
    logic [3:0]  wr_idx = '0;
    logic [31:0] wr_data = '0;
    logic        rd_sel = 1'b0;
    logic [3:0]  rd_idx = '0;
    logic [31:0] rd_data;
    logic [33:0] acc_addr = '0;
    logic [1:0]  acc_kind = '0;
    logic        acc_mmode = 1'b0;
    logic        acc_allow;
    logic        acc_hit;
    logic [3:0]  acc_idx;

    int    n_checks = 0;
    int    n_fail   = 0;
    int    cycles   = 0;
    bit    running  = 1'b0;
    string cur_req  = "R2";

    logic [7:0]  m_cfg  [16];
    logic [31:0] m_addr [16];

    always #10 clk = ~clk;

    pmp_guard i_pmp_guard (
        .clk(clk), .rst(rst), .wr_en(wr_en), .wr_sel(wr_sel), .wr_idx(wr_idx),
        .wr_data(wr_data), .rd_sel(rd_sel), .rd_idx(rd_idx), .rd_data(rd_data),
        .acc_addr(acc_addr), .acc_kind(acc_kind), .acc_mmode(acc_mmode),
        .acc_allow(acc_allow), .acc_hit(acc_hit), .acc_idx(acc_idx)
    );

    // Reference register state
    always @(posedge clk) begin
        if (rst) begin
            for (int i = 0; i < 16; i++) begin
                m_cfg[i]  <= 8'h00;
                m_addr[i] <= 32'h0;
            end
        end else if (wr_en && !m_cfg[wr_idx][7]) begin
            if (wr_sel) m_addr[wr_idx] <= wr_data;
            else        m_cfg[wr_idx]  <= wr_data[7:0] & 8'h9F;
        end
    end

    function automatic bit ref_match(int i, longint wa);
        int     mode;
        longint hi, lo, base, words;
        int     k;
        mode = int'(m_cfg[i][4:3]);
        hi   = longint'(m_addr[i]);
        if (mode == 1) begin
            lo = (i == 0) ? 0 : longint'(m_addr[i-1]);
            return (wa >= lo) && (wa < hi);
        end
        if (mode == 3) begin
            k = 0;
            while (k < 32 && m_addr[i][k]) k++;
            if (k >= 32) return 1'b1;
            words = longint'(1) << (k + 1);
            base  = (hi >> (k + 1)) << (k + 1);
            return (wa >= base) && (wa < base + words);
        end
        return 1'b0;
    endfunction

    task automatic compare_now();
        longint wa;
        bit     e_hit;
        int     e_idx;
        bit     e_allow;
        bit     perm;
        logic [31:0] e_rd;
        wa    = longint'(acc_addr[33:2]);
        e_hit = 1'b0;
        e_idx = 0;
        for (int i = 0; i < 16; i++) begin
            if (!e_hit && ref_match(i, wa)) begin
                e_hit = 1'b1;
                e_idx = i;
            end
        end
        if (e_hit) begin
            if (acc_kind == 2'd0)      perm = m_cfg[e_idx][0];
            else if (acc_kind == 2'd1) perm = m_cfg[e_idx][1];
            else                       perm = m_cfg[e_idx][2];
            e_allow = (acc_mmode && !m_cfg[e_idx][7]) ? 1'b1 : perm;
        end else begin
            e_allow = acc_mmode;
        end
        e_rd = rd_sel ? m_addr[rd_idx] : {24'h0, m_cfg[rd_idx]};

        n_checks++;
        if (acc_allow !== e_allow) begin
            n_fail++;
            $display("FAIL %s allow: actual %b expected %b (addr %h kind %0d m %b)",
                     cur_req, acc_allow, e_allow, acc_addr, acc_kind, acc_mmode);
        end
        n_checks++;
        if (acc_hit !== e_hit) begin
            n_fail++;
            $display("FAIL R11 hit: actual %b expected %b (addr %h)", acc_hit, e_hit, acc_addr);
        end
        if (e_hit) begin
            n_checks++;
            if (acc_idx !== 4'(e_idx)) begin
                n_fail++;
                $display("FAIL R7 index: actual %0d expected %0d (addr %h)", acc_idx, e_idx, acc_addr);
            end
        end
        n_checks++;
        if (rd_data !== e_rd) begin
            n_fail++;
            $display("FAIL %s readback: actual %h expected %h (sel %b idx %0d)",
                     cur_req, rd_data, e_rd, rd_sel, rd_idx);
        end
    endtask

    always @(posedge clk) begin
        #5;
        if (running) compare_now();
    end

    task automatic report();
        $display("End of test - %0d assertions evaluated, %0d failures", n_checks, n_fail);
    endtask

    always @(posedge clk) begin
        cycles++;
        if (cycles > 150000) begin
            n_fail++;
            $display("FAIL watchdog: actual %0d cycles expected completion", cycles);
            report();
            $finish;
        end
    end

    task automatic do_reset();
        @(negedge clk);
        rst   = 1'b1;
        wr_en = 1'b0;
        repeat (2) @(negedge clk);
        rst = 1'b0;
    endtask

    task automatic wr(bit sel, int idx, logic [31:0] data);
        @(negedge clk);
        wr_en = 1'b1; wr_sel = sel; wr_idx = 4'(idx); wr_data = data;
        rd_sel = sel; rd_idx = 4'(idx);
        @(negedge clk);
        wr_en = 1'b0;
    endtask

    task automatic acc(logic [33:0] a, int kind, bit m);
        @(negedge clk);
        acc_addr = a; acc_kind = 2'(kind); acc_mmode = m;
    endtask

    initial begin
        running = 1'b1;
        repeat (3) @(negedge clk);
        // R2: reset values
        cur_req = "R2";
        rst = 1'b0;
        for (int i = 0; i < 16; i++) begin
            @(negedge clk); rd_sel = 1'b0; rd_idx = 4'(i);
            @(negedge clk); rd_sel = 1'b1;
        end

        // R10: empty table
        cur_req = "R10";
        acc(34'h100, 0, 1'b1);
        acc(34'h100, 1, 1'b0);
        acc(34'h3_FFFF_FFFC, 2, 1'b0);

        // R1: field layout, reserved bits cleared
        cur_req = "R1";
        wr(1'b0, 5, 32'hFFFF_FF7F);
        wr(1'b1, 5, 32'hDEAD_BEEF);
        wr(1'b0, 5, 32'h0);

        // R5: top-of-range chain
        cur_req = "R5";
        wr(1'b1, 0, 32'h100);
        wr(1'b0, 0, 32'h09);
        wr(1'b1, 1, 32'h200);
        wr(1'b0, 1, 32'h0A);
        acc(34'h3FC, 0, 1'b0);
        acc(34'h000, 0, 1'b0);
        acc(34'h400, 0, 1'b0);
        acc(34'h400, 1, 1'b0);
        acc(34'h7FF, 1, 1'b0);
        acc(34'h800, 1, 1'b0);

        // R6: aligned regions, 4 KiB and 8 bytes
        cur_req = "R6";
        wr(1'b1, 2, 32'h0000_41FF);
        wr(1'b0, 2, 32'h1C);
        wr(1'b1, 3, 32'h0000_8000);
        wr(1'b0, 3, 32'h19);
        acc(34'h0_0000_FFFC, 2, 1'b0);
        acc(34'h0_0001_0000, 2, 1'b0);
        acc(34'h0_0001_0FFF, 2, 1'b0);
        acc(34'h0_0001_1000, 2, 1'b0);
        acc(34'h0_0002_0000, 0, 1'b0);
        acc(34'h0_0002_0007, 0, 1'b0);
        acc(34'h0_0002_0008, 0, 1'b0);

        // R8: each kind against a read-only entry
        cur_req = "R8";
        acc(34'h0_0002_0004, 1, 1'b0);
        acc(34'h0_0002_0004, 2, 1'b0);
        acc(34'h0_0002_0004, 3, 1'b0);
        acc(34'h0_0001_0010, 3, 1'b0);

        // R4: modes 0 and 2 never match
        cur_req = "R4";
        wr(1'b0, 3, 32'h11);
        acc(34'h0_0002_0000, 0, 1'b0);
        wr(1'b0, 3, 32'h01);
        acc(34'h0_0002_0000, 0, 1'b0);

        // R7: overlap, lower index wins
        cur_req = "R7";
        wr(1'b1, 4, 32'h0000_41FF);
        wr(1'b0, 4, 32'h1B);
        wr(1'b1, 6, 32'hFFFF_FFFF);
        wr(1'b0, 6, 32'h1F);
        acc(34'h0_0001_0020, 0, 1'b0);
        acc(34'h0_0001_0020, 2, 1'b0);
        acc(34'h2_0000_0000, 1, 1'b0);
        acc(34'h0_0000_0010, 1, 1'b0);

        // R9: machine mode versus lock
        cur_req = "R9";
        acc(34'h0_0001_0020, 1, 1'b1);
        wr(1'b0, 2, 32'h9C);
        acc(34'h0_0001_0020, 1, 1'b1);
        acc(34'h0_0001_0020, 2, 1'b1);
        acc(34'h0_0000_0500, 0, 1'b1);

        // R3: locked entry ignores writes
        cur_req = "R3";
        wr(1'b0, 2, 32'h07);
        wr(1'b1, 2, 32'h0000_0000);
        @(negedge clk); rd_sel = 1'b0; rd_idx = 4'd2;
        @(negedge clk); rd_sel = 1'b1;
        acc(34'h0_0001_0020, 1, 1'b1);
        do_reset();
        cur_req = "R2";
        @(negedge clk); rd_sel = 1'b0; rd_idx = 4'd2;
        @(negedge clk); rd_sel = 1'b1;

        // Random mix over a small window
        cur_req = "R11";
        for (int n = 0; n < 6000; n++) begin
            @(negedge clk);
            if (n % 1500 == 1499) begin
                rst = 1'b1;
            end else begin
                rst = 1'b0;
            end
            wr_en   = ($urandom_range(0, 3) == 0);
            wr_sel  = 1'($urandom_range(0, 1));
            wr_idx  = 4'($urandom_range(0, 15));
            if (wr_sel) begin
                if ($urandom_range(0, 1) == 0)
                    wr_data = 32'($urandom_range(0, 4095));
                else
                    wr_data = (32'($urandom_range(0, 255)) << 4) | 32'((1 << $urandom_range(0, 4)) - 1);
            end else begin
                wr_data = 32'($urandom());
                if ($urandom_range(0, 7) != 0) wr_data[7] = 1'b0;
            end
            rd_sel    = 1'($urandom_range(0, 1));
            rd_idx    = 4'($urandom_range(0, 15));
            acc_addr  = 34'($urandom_range(0, 16383));
            acc_kind  = 2'($urandom_range(0, 3));
            acc_mmode = 1'($urandom_range(0, 1));
        end
        @(negedge clk);
        rst = 1'b0; wr_en = 1'b0;
        repeat (2) @(negedge clk);
        running = 1'b0;
        report();
        $finish;
    end

endmodule